// File: doc/BRIEF.md
# Symbolic Input Constraint Buffer

This block keeps track of the memory words a transaction reads while their conflicts are deliberately ignored. When such a load is tracked, the caller gives the word's address and the value it saw. The block takes them into a free entry, and the caller skips setting the read bit on that line. Later, when a branch depends on a value that is "tracked input plus offset" compared with a constant, the caller reports the comparison, the offset, the constant and the branch outcome. The block turns that report into a bound on the input alone and merges it with the bounds already held. An operation that cannot be tracked pins the input to the value first seen.

At commit the caller reacquires each tracked word and presents its current value, one per cycle, marking the final one. One cycle after the final value the block reports pass, meaning repair may proceed, or fail, meaning abort. A fail caused by a violated bound also names the address whose predictor entry should be trained down. The result cycle frees every entry for the next transaction. A merge that leaves no legal value is signalled at once, so the caller can abort early.

Top module: `sib_constraint_buf`

## Requirements
- R1: A request to track a load is granted in the same cycle to the lowest-numbered free entry, reported on `alloc_slot`; the entry holds the address and value from the following cycle.
- R2: When all 8 entries are in use, or a commit check is presented in the same cycle, a tracking request is refused: `alloc_grant` stays low and `alloc_fallback` is high, so the caller uses ordinary read-bit tracking.
- R3: Constraint kinds use this encoding: 2'b00 means the branch tested (input+offset) < constant, 2'b01 means it tested (input+offset) >= constant, 2'b10 pins the input, and 2'b11 has no effect. A taken less-than or a not-taken greater-or-equal bounds the input below constant-offset. A taken greater-or-equal or a not-taken less-than requires input >= constant-offset. All values are signed 32-bit, and the threshold is formed without wrap-around.
- R4: Several bounds on one entry merge to the tightest lower bound and the tightest upper bound; a looser bound added later changes nothing.
- R5: A pinned entry passes only if its reacquired value equals the value captured when it was allocated.
- R6: `unsat` rises in the cycle after a constraint leaves an entry with no legal value, and stays high until the commit result clears the buffer.
- R7: A commit is a run of cycles with `chk_req` high, one entry per cycle, the last marked by `chk_last`. In the cycle after that last one, `res_valid` pulses for one cycle. `res_pass` is high exactly when every allocated entry was checked and every checked value met its constraints.
- R8: On a fail with at least one violated constraint, `train_valid` pulses with `res_valid`, and `train_addr` holds the address of the first violating entry in check order. A fail caused only by unchecked entries leaves `train_valid` low.
- R9: A check presented for a slot that holds no entry has no effect on the result.
- R10: The commit result cycle frees every entry, so the next grant is slot 0.
- R11: A constraint aimed at a free slot is ignored. A grant and a constraint on another entry in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_req | input | 1 | Request to track a load |
| alloc_addr | input | 32 | Address of the tracked word |
| alloc_value | input | 32 | Value observed by the load |
| alloc_grant | output | 1 | Request accepted this cycle |
| alloc_slot | output | 3 | Entry given to the request |
| alloc_fallback | output | 1 | Request refused; use read-bit tracking |
| cons_req | input | 1 | Constraint report valid |
| cons_slot | input | 3 | Entry the constraint refers to |
| cons_kind | input | 2 | Comparison kind (see R3) |
| cons_taken | input | 1 | Branch outcome |
| cons_offset | input | 32 | Offset added to the input in the branch |
| cons_const | input | 32 | Constant compared against |
| chk_req | input | 1 | Reacquired value valid |
| chk_slot | input | 3 | Entry being checked |
| chk_value | input | 32 | Reacquired current value |
| chk_last | input | 1 | Final value of the commit |
| res_valid | output | 1 | Commit result pulse |
| res_pass | output | 1 | Repair allowed |
| train_valid | output | 1 | Train the predictor down |
| train_addr | output | 32 | Address to train down |
| unsat | output | 1 | Some entry has an empty range |

## Verification
A tracking grant and a constraint report can land in the same cycle on different entries. The bench provokes this by raising `alloc_req` and `cons_req` together, with the constraint aimed at an entry granted earlier. It judges the outcome through the commit result: the earlier entry must fail against its new bound and the new entry must still be held. The second overlap is a commit check meeting a tracking request. The bench raises both in one cycle and expects a refusal with fallback, and the following result must be unaffected.

// File: rtl/sib_pkg.sv
// Package: shared types for the symbolic input constraint buffer.
// Assumes 2-bit constraint kind encoding as listed in the brief (R3).
package sib_pkg;

    // Constraint kind as presented on the port
    typedef enum logic [1:0] {
        CK_LESS = 2'b00,
        CK_GEQ  = 2'b01,
        CK_PIN  = 2'b10,
        CK_NONE = 2'b11
    } cons_kind_e;

    // Narrowing action after translating a branch onto the input alone
    typedef enum logic [1:0] {
        NARROW_NONE = 2'b00,
        NARROW_HI   = 2'b01,
        NARROW_LO   = 2'b10,
        NARROW_PIN  = 2'b11
    } narrow_e;

endpackage

// File: rtl/sib_alloc.sv
// Module: sib_alloc
// Finds the lowest free entry and grants a tracking request to it.
// Assumes ENTRIES >= 2. Purely combinational.
module sib_alloc #(
    parameter int ENTRIES = 8,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic               req,
    input  logic               block,
    output logic               grant,
    output logic [IDX_W-1:0]   slot,
    output logic               fallback
);

    logic free_found;

    // Priority search for the lowest free entry
    always_comb begin
        free_found = 1'b0;
        slot       = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!valid_vec[i] && !free_found) begin
                free_found = 1'b1;
                slot       = IDX_W'(i);
            end
        end
    end

    // Grant unless full or blocked by a commit check
    always_comb begin
        grant    = req && !block && free_found;
        fallback = req && !grant;
    end

endmodule

// File: rtl/sib_entry.sv
// Module: sib_entry
// One tracked input: address, first-seen value, merged signed bounds
// [lo, hi) and a pin flag. Evaluates a reacquired value against them.
// Assumes allocation and clear never coincide (the top blocks that).
module sib_entry
    import sib_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int BW = DATA_W + 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  alloc_we,
    input  logic [ADDR_W-1:0]     alloc_addr,
    input  logic [DATA_W-1:0]     alloc_value,
    input  logic                  narrow_we,
    input  narrow_e               narrow,
    input  logic signed [BW-1:0]  thr,
    input  logic                  clear,
    input  logic [DATA_W-1:0]     probe_value,
    output logic                  valid_o,
    output logic [ADDR_W-1:0]     addr_o,
    output logic                  unsat_o,
    output logic                  ok_o
);

    localparam logic signed [BW-1:0] LO_INIT = {3'b111, {(DATA_W-1){1'b0}}};
    localparam logic signed [BW-1:0] HI_INIT = {3'b001, {(DATA_W-1){1'b0}}};

    logic                 valid_q;
    logic [ADDR_W-1:0]    addr_q;
    logic [DATA_W-1:0]    orig_q;
    logic signed [BW-1:0] lo_q;
    logic signed [BW-1:0] hi_q;
    logic                 pin_q;
    logic signed [BW-1:0] orig_ext;
    logic signed [BW-1:0] probe_ext;

    // Capture on allocation, tighten bounds on constraints, free on clear
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            valid_q <= 1'b0;
            addr_q  <= '0;
            orig_q  <= '0;
            lo_q    <= LO_INIT;
            hi_q    <= HI_INIT;
            pin_q   <= 1'b0;
        end else if (alloc_we) begin
            valid_q <= 1'b1;
            addr_q  <= alloc_addr;
            orig_q  <= alloc_value;
            lo_q    <= LO_INIT;
            hi_q    <= HI_INIT;
            pin_q   <= 1'b0;
        end else if (narrow_we && valid_q) begin
            case (narrow)
                NARROW_HI:  if (thr < hi_q) hi_q <= thr;
                NARROW_LO:  if (thr > lo_q) lo_q <= thr;
                NARROW_PIN: pin_q <= 1'b1;
                default:    ;
            endcase
        end
    end

    // Sign-extend stored and probed values to bound width
    always_comb begin
        orig_ext  = $signed({{2{orig_q[DATA_W-1]}}, orig_q});
        probe_ext = $signed({{2{probe_value[DATA_W-1]}}, probe_value});
    end

    // Flag an empty legal range and judge the probed value
    always_comb begin
        unsat_o = valid_q && ((lo_q >= hi_q) ||
                  (pin_q && ((orig_ext < lo_q) || (orig_ext >= hi_q))));
        ok_o    = (probe_ext >= lo_q) && (probe_ext < hi_q) &&
                  (!pin_q || (probe_value == orig_q));
        valid_o = valid_q;
        addr_o  = addr_q;
    end

    // R5: a pin, once set, survives until the entry is cleared
    p_pin_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_q && !clear && !alloc_we) |=> pin_q);

    // R4: bounds only ever tighten while the entry is held
    p_bounds_tighten_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !clear && !alloc_we) |=> (hi_q <= $past(hi_q)) && (lo_q >= $past(lo_q)));

endmodule

// File: rtl/sib_verdict.sv
// Module: sib_verdict
// Accumulates per-entry check outcomes during a commit and registers the
// final pass/fail and train-down address one cycle after the last value.
// Assumes ok_vec reflects the value on chk_value for the addressed entry.
module sib_verdict #(
    parameter int ENTRIES = 8,
    parameter int ADDR_W = 32,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               chk_req,
    input  logic [IDX_W-1:0]   chk_slot,
    input  logic               chk_last,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic [ENTRIES-1:0] ok_vec,
    input  logic [ADDR_W-1:0]  addr_arr [ENTRIES],
    output logic               finish,
    output logic               res_valid,
    output logic               res_pass,
    output logic               train_valid,
    output logic [ADDR_W-1:0]  train_addr
);

    logic [ENTRIES-1:0] checked_q, checked_n;
    logic               viol_q, viol_n;
    logic [ADDR_W-1:0]  first_q, first_n;
    logic               hit, viol;
    logic               missing;

    // Next accumulator state for the check presented this cycle
    always_comb begin
        hit       = chk_req && (int'(chk_slot) < ENTRIES) && valid_vec[chk_slot];
        viol      = hit && !ok_vec[chk_slot];
        checked_n = checked_q;
        if (hit) checked_n[chk_slot] = 1'b1;
        viol_n    = viol_q || viol;
        first_n   = (viol && !viol_q) ? addr_arr[chk_slot] : first_q;
        finish    = chk_req && chk_last;
        missing   = |(valid_vec & ~checked_n);
    end

    // Accumulate during the commit, publish and reset on its last value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            checked_q   <= '0;
            viol_q      <= 1'b0;
            first_q     <= '0;
            res_valid   <= 1'b0;
            res_pass    <= 1'b0;
            train_valid <= 1'b0;
            train_addr  <= '0;
        end else if (finish) begin
            checked_q   <= '0;
            viol_q      <= 1'b0;
            first_q     <= '0;
            res_valid   <= 1'b1;
            res_pass    <= !viol_n && !missing;
            train_valid <= viol_n;
            train_addr  <= first_n;
        end else begin
            checked_q   <= checked_n;
            viol_q      <= viol_n;
            first_q     <= first_n;
            res_valid   <= 1'b0;
            res_pass    <= 1'b0;
            train_valid <= 1'b0;
        end
    end

    // R7: a result appears only the cycle after a final check value
    p_result_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(chk_req && chk_last));

    // R8: training only ever accompanies a failing result
    p_train_on_fail_r8: assert property (@(posedge clk) disable iff (!rst_n)
        train_valid |-> (res_valid && !res_pass));

endmodule

// File: rtl/sib_constraint_buf.sv
// Module: sib_constraint_buf (top)
// Tracked-input buffer: grants entries for loads whose conflicts are
// ignored, translates branch reports into bounds on the input, and checks
// reacquired values at commit. Assumes one check value per cycle and that
// the caller stops tracking new loads while a commit is presented.
module sib_constraint_buf
    import sib_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(ENTRIES),
    localparam int BW = DATA_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_req,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic [DATA_W-1:0] alloc_value,
    output logic              alloc_grant,
    output logic [IDX_W-1:0]  alloc_slot,
    output logic              alloc_fallback,
    input  logic              cons_req,
    input  logic [IDX_W-1:0]  cons_slot,
    input  logic [1:0]        cons_kind,
    input  logic              cons_taken,
    input  logic [DATA_W-1:0] cons_offset,
    input  logic [DATA_W-1:0] cons_const,
    input  logic              chk_req,
    input  logic [IDX_W-1:0]  chk_slot,
    input  logic [DATA_W-1:0] chk_value,
    input  logic              chk_last,
    output logic              res_valid,
    output logic              res_pass,
    output logic              train_valid,
    output logic [ADDR_W-1:0] train_addr,
    output logic              unsat
);

    logic [ENTRIES-1:0]   valid_vec;
    logic [ENTRIES-1:0]   ok_vec;
    logic [ENTRIES-1:0]   unsat_vec;
    logic [ADDR_W-1:0]    addr_arr [ENTRIES];
    narrow_e              narrow;
    logic signed [BW-1:0] thr;
    logic                 finish;

    // Turn a branch on (input + offset) into a bound on the input alone
    always_comb begin
        thr = $signed({{2{cons_const[DATA_W-1]}}, cons_const}) -
              $signed({{2{cons_offset[DATA_W-1]}}, cons_offset});
        case (cons_kind_e'(cons_kind))
            CK_LESS: narrow = cons_taken ? NARROW_HI : NARROW_LO;
            CK_GEQ:  narrow = cons_taken ? NARROW_LO : NARROW_HI;
            CK_PIN:  narrow = NARROW_PIN;
            default: narrow = NARROW_NONE;
        endcase
    end

    sib_alloc #(.ENTRIES(ENTRIES)) alloc_i (
        .valid_vec (valid_vec),
        .req       (alloc_req),
        .block     (chk_req),
        .grant     (alloc_grant),
        .slot      (alloc_slot),
        .fallback  (alloc_fallback)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        sib_entry #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) entry_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .alloc_we    (alloc_grant && (alloc_slot == IDX_W'(g))),
            .alloc_addr  (alloc_addr),
            .alloc_value (alloc_value),
            .narrow_we   (cons_req && (cons_slot == IDX_W'(g))),
            .narrow      (narrow),
            .thr         (thr),
            .clear       (finish),
            .probe_value (chk_value),
            .valid_o     (valid_vec[g]),
            .addr_o      (addr_arr[g]),
            .unsat_o     (unsat_vec[g]),
            .ok_o        (ok_vec[g])
        );
    end

    sib_verdict #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) verdict_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .chk_req     (chk_req),
        .chk_slot    (chk_slot),
        .chk_last    (chk_last),
        .valid_vec   (valid_vec),
        .ok_vec      (ok_vec),
        .addr_arr    (addr_arr),
        .finish      (finish),
        .res_valid   (res_valid),
        .res_pass    (res_pass),
        .train_valid (train_valid),
        .train_addr  (train_addr)
    );

    // Any entry with an empty legal range dooms the transaction
    always_comb unsat = |unsat_vec;

    // R1: a granted slot holds the granted address one cycle later
    p_grant_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_grant |=> valid_vec[$past(alloc_slot)] &&
                        (addr_arr[$past(alloc_slot)] == $past(alloc_addr)));

    // R2: refusal happens only when full or blocked by a check
    p_fallback_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_fallback |-> (&valid_vec || chk_req));

    // R10: the result cycle sees an empty buffer
    p_cleared_after_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(chk_req && chk_last) |-> (valid_vec == '0));

endmodule

// File: tb/sib_constraint_buf_tb_top.sv
// Scoreboard bench: drivers push expected commit results into a queue,
// a monitor pops and compares them when res_valid pulses.
module sib_constraint_buf_tb_top;

    typedef struct {
        bit          pass;
        bit          tv;
        logic [31:0] taddr;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_req = 1'b0;
    logic [31:0] alloc_addr = '0;
    logic [31:0] alloc_value = '0;
    logic        alloc_grant, alloc_fallback;
    logic [2:0]  alloc_slot;
    logic        cons_req = 1'b0;
    logic [2:0]  cons_slot = '0;
    logic [1:0]  cons_kind = '0;
    logic        cons_taken = 1'b0;
    logic [31:0] cons_offset = '0;
    logic [31:0] cons_const = '0;
    logic        chk_req = 1'b0;
    logic [2:0]  chk_slot = '0;
    logic [31:0] chk_value = '0;
    logic        chk_last = 1'b0;
    logic        res_valid, res_pass, train_valid, unsat;
    logic [31:0] train_addr;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #10 clk = ~clk;

    sib_constraint_buf dut_i (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(alloc_req), .alloc_addr(alloc_addr), .alloc_value(alloc_value),
        .alloc_grant(alloc_grant), .alloc_slot(alloc_slot), .alloc_fallback(alloc_fallback),
        .cons_req(cons_req), .cons_slot(cons_slot), .cons_kind(cons_kind),
        .cons_taken(cons_taken), .cons_offset(cons_offset), .cons_const(cons_const),
        .chk_req(chk_req), .chk_slot(chk_slot), .chk_value(chk_value), .chk_last(chk_last),
        .res_valid(res_valid), .res_pass(res_pass), .train_valid(train_valid),
        .train_addr(train_addr), .unsat(unsat)
    );

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_alloc(logic [31:0] a, logic [31:0] v, bit exp_g, int exp_s, string req);
        @(negedge clk);
        alloc_req = 1'b1; alloc_addr = a; alloc_value = v;
        #1;
        check(alloc_grant == exp_g, req, "alloc_grant", alloc_grant, exp_g);
        check(alloc_fallback == !exp_g, req, "alloc_fallback", alloc_fallback, !exp_g);
        if (exp_g) check(alloc_slot == exp_s, req, "alloc_slot", alloc_slot, exp_s);
        @(posedge clk); #1;
        alloc_req = 1'b0;
    endtask

    task automatic do_cons(int s, logic [1:0] k, bit t, int off, int c);
        @(negedge clk);
        cons_req = 1'b1; cons_slot = 3'(s); cons_kind = k; cons_taken = t;
        cons_offset = off; cons_const = c;
        @(posedge clk); #1;
        cons_req = 1'b0;
    endtask

    task automatic chk_item(int s, int v, bit last);
        @(negedge clk);
        chk_req = 1'b1; chk_slot = 3'(s); chk_value = v; chk_last = last;
        @(posedge clk); #1;
        chk_req = 1'b0; chk_last = 1'b0;
    endtask

    task automatic expect_res(bit p, bit tv, logic [31:0] ta, string tag);
        exp_t e;
        e.pass = p; e.tv = tv; e.taddr = ta; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare each result pulse against the scoreboard head
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R7", "unexpected res_valid", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(res_pass == e.pass, e.tag, "res_pass", res_pass, e.pass);
                check(train_valid == e.tv, e.tag, "train_valid", train_valid, e.tv);
                if (e.tv) check(train_addr == e.taddr, e.tag, "train_addr", train_addr, e.taddr);
            end
        end
    end

    // Range merge scenario for R4: legal range ends up [2,10)
    task automatic setup_merge();
        do_alloc(32'h100, 0, 1, 0, "R4");
        do_cons(0, 2'b00, 1, 0, 10);
        do_cons(0, 2'b00, 1, 0, 20);
        do_cons(0, 2'b01, 1, 0, 2);
        do_cons(0, 2'b01, 1, 0, -3);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(res_valid == 0 && unsat == 0 && alloc_grant == 0, "R7", "reset state", res_valid, 0);

        // R3: not-taken (a+1) >= 8 gives a < 7; 4 passes, 7 fails
        do_alloc(32'hA000, 2, 1, 0, "R1");
        do_cons(0, 2'b01, 0, 1, 8);
        expect_res(1, 0, 0, "R3");
        chk_item(0, 4, 1);
        do_alloc(32'hA000, 2, 1, 0, "R10");
        do_cons(0, 2'b01, 0, 1, 8);
        expect_res(0, 1, 32'hA000, "R3");
        chk_item(0, 7, 1);

        // R5: pinned input must equal captured value
        do_alloc(32'hB000, 5, 1, 0, "R1");
        do_cons(0, 2'b10, 0, 0, 0);
        expect_res(1, 0, 0, "R5");
        chk_item(0, 5, 1);
        do_alloc(32'hB000, 5, 1, 0, "R1");
        do_cons(0, 2'b10, 0, 0, 0);
        expect_res(0, 1, 32'hB000, "R5");
        chk_item(0, 6, 1);

        // R4: tightest bounds kept
        setup_merge();
        expect_res(1, 0, 0, "R4");
        chk_item(0, 9, 1);
        setup_merge();
        expect_res(0, 1, 32'h100, "R4");
        chk_item(0, 10, 1);
        setup_merge();
        expect_res(0, 1, 32'h100, "R4");
        chk_item(0, 1, 1);

        // R1/R2: fill all eight, ninth falls back; kind 11 has no effect (R3)
        for (int i = 0; i < 8; i++) do_alloc(32'h2000 + 32'(i * 4), i * 3, 1, i, "R1");
        do_alloc(32'h3000, 1, 0, 0, "R2");
        do_cons(4, 2'b11, 1, 0, -100);
        expect_res(1, 0, 0, "R2");
        for (int i = 0; i < 8; i++) chk_item(i, i * 3, i == 7);

        // R8: unchecked entry fails without training; R2 refusal during check
        do_alloc(32'h4000, 1, 1, 0, "R10");
        do_alloc(32'h4004, 2, 1, 1, "R1");
        expect_res(0, 0, 0, "R8");
        @(negedge clk);
        chk_req = 1'b1; chk_slot = 0; chk_value = 1; chk_last = 1'b1;
        alloc_req = 1'b1; alloc_addr = 32'h5000;
        #1;
        check(alloc_grant == 0, "R2", "grant during check", alloc_grant, 0);
        check(alloc_fallback == 1, "R2", "fallback during check", alloc_fallback, 1);
        @(posedge clk); #1;
        chk_req = 1'b0; chk_last = 1'b0; alloc_req = 1'b0;

        // R6: contradictory bounds raise unsat next cycle
        do_alloc(32'h6000, 7, 1, 0, "R10");
        do_cons(0, 2'b01, 1, 0, 10);
        @(negedge clk);
        check(unsat == 0, "R6", "unsat before", unsat, 0);
        do_cons(0, 2'b00, 1, 0, 5);
        @(negedge clk);
        check(unsat == 1, "R6", "unsat after", unsat, 1);
        expect_res(0, 1, 32'h6000, "R6");
        chk_item(0, 7, 1);
        @(negedge clk);
        check(unsat == 0, "R6", "unsat cleared", unsat, 0);

        // R11: grant and constraint on another entry in the same cycle
        do_alloc(32'h7000, 1, 1, 0, "R1");
        @(negedge clk);
        alloc_req = 1'b1; alloc_addr = 32'h7004; alloc_value = 9;
        cons_req = 1'b1; cons_slot = 0; cons_kind = 2'b00; cons_taken = 1'b1;
        cons_offset = 0; cons_const = 3;
        #1;
        check(alloc_grant == 1 && alloc_slot == 1, "R11", "same-cycle grant", alloc_slot, 1);
        @(posedge clk); #1;
        alloc_req = 1'b0; cons_req = 1'b0;
        expect_res(0, 1, 32'h7000, "R11");
        chk_item(1, 9, 0);
        chk_item(0, 5, 1);

        // R11: constraint to a free slot ignored; R9: check to free slot ignored
        do_cons(1, 2'b00, 1, 0, -100);
        do_alloc(32'h8000, 0, 1, 0, "R10");
        do_alloc(32'h8004, 0, 1, 1, "R11");
        expect_res(1, 0, 0, "R9");
        chk_item(5, 123, 0);
        chk_item(0, 0, 0);
        chk_item(1, 0, 1);

        // R3/R8: signed thresholds, first violation in check order is named
        do_alloc(32'h9000, -10, 1, 0, "R3");
        do_alloc(32'h9004, 3, 1, 1, "R3");
        do_cons(0, 2'b00, 1, 0, -5);
        do_cons(1, 2'b01, 1, -2, 4);
        expect_res(0, 1, 32'h9004, "R8");
        chk_item(1, 5, 0);
        chk_item(0, -5, 1);
        do_alloc(32'h9000, -10, 1, 0, "R3");
        do_alloc(32'h9004, 3, 1, 1, "R3");
        do_cons(0, 2'b00, 1, 0, -5);
        do_cons(1, 2'b01, 1, -2, 4);
        expect_res(1, 0, 0, "R3");
        chk_item(0, -6, 0);
        chk_item(1, 6, 1);

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R7", "results outstanding", sb.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule